// File: doc/BRIEF.md
# Program-Counter Breakpoint and Branch Trace Unit

This block sits beside a processor core and watches the address of every executed instruction. Four address comparators, each with its own enable, flag matching instructions. A preset down-counter turns those matches into a trap request to the core. In its alternate mode the counter instead counts executed instructions that come from the instruction cache loop. Matching has no interrupt mask input, so an address inside an interrupt service routine matches like any other.

The unit also records control-flow discontinuities. When an executed address is not the previous executed address plus one, it stores the pair (address before the jump, address after it) in a four-entry circular trace. Once the trace is full, each new pair overwrites the oldest one. Software sets up the comparators, the mode and the counter preset through a small register port, and reads the trace back through the same port, oldest pair first.

In a multi-processor system, a local trap is driven out on a trap-out pin. A trap-in pin lets a breakpoint reached on another processor trap this core as well. Trap-in is never forwarded to trap-out, so processors can be wired to one another without forming a loop.

Top module: `pc_watch`

## Requirements
- R1: After reset, trap_req_o and trap_out_o are low. The control register (address 8) reads 0, with every comparator disabled. The counter register (address 9) reads 0 and the counter is disarmed. The trace level (address 10) reads 0.
- R2: Comparator n (0..3) holds an address written at register address n. It matches only when exec_i is high, its enable bit (control bit n) is set, and pc_i equals its address. A disabled comparator never changes the counter.
- R3: In break-count mode (control bit 4 = 0), each executed instruction that matches at least one enabled comparator decrements the armed counter once. On the hit that takes the counter from 1 to 0, trap_req_o and trap_out_o are high for exactly the one following cycle.
- R4: In cache-count mode (control bit 4 = 1), the counter decrements on each cycle where exec_i and cache_i are both high. Comparator hits and cache_i without exec_i have no effect.
- R5: Writing N at address 9 arms the counter with N, or disarms it when N is 0. A write takes precedence over a same-cycle event. After a trap the counter reads 0 and produces no further trap until it is written again.
- R6: trap_in_i high in a cycle makes trap_req_o high in the next cycle. trap_out_o follows only local counter traps.
- R7: On an executed instruction, provided an earlier instruction has executed since reset, a pair {previous address, pc_i} is recorded if pc_i differs from the previous executed address plus one, modulo 2^16. Cycles without exec_i neither record a pair nor change the previous address.
- R8: The trace keeps the last four pairs, and its level saturates at 4. Trace entry k (0 = oldest) is read with its source at address 16+2k and its destination at 17+2k. Entries at or beyond the level read 0.
- R9: Unmapped register addresses (4..7, 11..15) read 0. Reads are combinational from reg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 16 | Address of the instruction executing this cycle |
| exec_i | input | 1 | An instruction executed this cycle |
| cache_i | input | 1 | The executed instruction came from the cache loop |
| trap_in_i | input | 1 | Trap raised by another processor |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| trap_req_o | output | 1 | Trap request to the local core |
| trap_out_o | output | 1 | Local trap signalled to other processors |

## Verification
The bench builds the block with its defaults: a 16-bit address, four comparators, a four-pair trace and a 5-bit register address. With these values, pc wrap-around at 0xFFFF is reachable in a few cycles, so the bench can show that this step counts as sequential. The small trace lets short jump bursts reach saturation and overwrite the oldest pairs. The bench also sweeps the whole 32-entry register space, which covers the unfilled trace slots and the unmapped holes.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  // Register map offsets
  localparam int unsigned REG_CTRL  = 8;
  localparam int unsigned REG_COUNT = 9;
  localparam int unsigned REG_LEVEL = 10;
  localparam int unsigned REG_TRACE = 16;

  typedef enum logic {
    CNT_BREAK = 1'b0,
    CNT_CACHE = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/bp_match.sv
module bp_match #(
  parameter int AW  = 16,
  parameter int NBP = 4
) (
  input  logic [AW-1:0]          pc_i,
  input  logic                   exec_i,
  input  logic [NBP-1:0]         en_i,
  input  logic [NBP-1:0][AW-1:0] addr_i,
  output logic                   any_hit_o
);
  logic [NBP-1:0] hit_vec;

  for (genvar g = 0; g < NBP; g++) begin : g_cmp
    assign hit_vec[g] = exec_i && en_i[g] && (addr_i[g] == pc_i);
  end

  assign any_hit_o = |hit_vec;
endmodule

// File: rtl/trap_count.sv
module trap_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          event_i,
  output logic [CW-1:0] count_o,
  output logic          armed_o,
  output logic          fire_o,
  output logic          fire_q_o
);
  function automatic logic last_step(logic [CW-1:0] c);
    return c == CW'(1);
  endfunction

  assign fire_o = event_i && armed_o && !load_i && last_step(count_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o  <= '0;
      armed_o  <= 1'b0;
      fire_q_o <= 1'b0;
    end else begin
      fire_q_o <= fire_o;
      if (load_i) begin
        count_o <= load_val_i;
        armed_o <= |load_val_i;
      end else if (event_i && armed_o) begin
        count_o <= count_o - CW'(1);
        if (last_step(count_o)) armed_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/branch_trace.sv
module branch_trace #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int IW    = 5,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic          exec_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_src_o,
  output logic [AW-1:0] rd_dst_o,
  output logic [LW-1:0] level_o,
  output logic          push_o
);
  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];
  logic [PW-1:0] wptr_q;
  logic [AW-1:0] prev_q;
  logic          prev_v_q;
  logic [PW-1:0] rd_slot;

  function automatic logic is_jump(logic [AW-1:0] prev, logic [AW-1:0] cur);
    return cur != (prev + AW'(1));
  endfunction

  // Physical slot of the k-th oldest entry (DEPTH is a power of two)
  function automatic logic [PW-1:0] slot_of(logic [PW-1:0] w, logic [LW-1:0] lv,
                                           logic [PW-1:0] k);
    return w - lv[PW-1:0] + k;
  endfunction

  assign push_o  = exec_i && prev_v_q && is_jump(prev_q, pc_i);
  assign rd_slot = slot_of(wptr_q, level_o, rd_idx_i[PW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      level_o  <= '0;
      prev_q   <= '0;
      prev_v_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      if (exec_i) begin
        prev_q   <= pc_i;
        prev_v_q <= 1'b1;
      end
      if (push_o) begin
        src_q[wptr_q] <= prev_q;
        dst_q[wptr_q] <= pc_i;
        wptr_q        <= wptr_q + PW'(1);
        if (level_o != LW'(DEPTH)) level_o <= level_o + LW'(1);
      end
    end
  end

  always_comb begin
    rd_src_o = '0;
    rd_dst_o = '0;
    if (int'(rd_idx_i) < int'(level_o)) begin
      rd_src_o = src_q[rd_slot];
      rd_dst_o = dst_q[rd_slot];
    end
  end
endmodule

// File: rtl/pc_watch.sv
module pc_watch
  import pcw_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NBP   = 4,
  parameter int DEPTH = 4,
  parameter int RAW   = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  pc_i,
  input  logic           exec_i,
  input  logic           cache_i,
  input  logic           trap_in_i,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [AW-1:0]  reg_wdata_i,
  output logic [AW-1:0]  reg_rdata_o,
  output logic           trap_req_o,
  output logic           trap_out_o
);
  localparam int PW  = $clog2(DEPTH);
  localparam int LVW = PW + 1;

  logic [NBP-1:0][AW-1:0] bp_q;
  logic [NBP-1:0]         en_q;
  cnt_mode_e              mode_q;
  logic                   ext_q;

  // Named internal events
  logic           bp_hit_any;
  logic           cnt_event;
  logic           cnt_load;
  logic           cnt_fire;
  logic           cnt_fire_q;
  logic           cnt_armed;
  logic [AW-1:0]  cnt_value;
  logic           trace_push;
  logic [LVW-1:0] trace_level;
  logic [RAW-1:0] trace_idx;
  logic [AW-1:0]  trace_src;
  logic [AW-1:0]  trace_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_q   <= '0;
      en_q   <= '0;
      mode_q <= CNT_BREAK;
      ext_q  <= 1'b0;
    end else begin
      ext_q <= trap_in_i;
      for (int i = 0; i < NBP; i++) begin
        if (reg_we_i && reg_addr_i == RAW'(i)) bp_q[i] <= reg_wdata_i;
      end
      if (reg_we_i && reg_addr_i == RAW'(REG_CTRL)) begin
        en_q   <= reg_wdata_i[NBP-1:0];
        mode_q <= cnt_mode_e'(reg_wdata_i[NBP]);
      end
    end
  end

  bp_match #(.AW(AW), .NBP(NBP)) u_match (
    .pc_i      (pc_i),
    .exec_i    (exec_i),
    .en_i      (en_q),
    .addr_i    (bp_q),
    .any_hit_o (bp_hit_any)
  );

  assign cnt_event = (mode_q == CNT_CACHE) ? (exec_i && cache_i) : bp_hit_any;
  assign cnt_load  = reg_we_i && (reg_addr_i == RAW'(REG_COUNT));

  trap_count #(.CW(AW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (reg_wdata_i),
    .event_i    (cnt_event),
    .count_o    (cnt_value),
    .armed_o    (cnt_armed),
    .fire_o     (cnt_fire),
    .fire_q_o   (cnt_fire_q)
  );

  assign trace_idx = (reg_addr_i - RAW'(REG_TRACE)) >> 1;

  branch_trace #(.AW(AW), .DEPTH(DEPTH), .IW(RAW)) u_trace (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_i     (pc_i),
    .exec_i   (exec_i),
    .rd_idx_i (trace_idx),
    .rd_src_o (trace_src),
    .rd_dst_o (trace_dst),
    .level_o  (trace_level),
    .push_o   (trace_push)
  );

  assign trap_out_o = cnt_fire_q;
  assign trap_req_o = cnt_fire_q | ext_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NBP; i++) begin
      if (reg_addr_i == RAW'(i)) reg_rdata_o = bp_q[i];
    end
    if (reg_addr_i == RAW'(REG_CTRL))  reg_rdata_o = AW'({mode_q, en_q});
    if (reg_addr_i == RAW'(REG_COUNT)) reg_rdata_o = cnt_value;
    if (reg_addr_i == RAW'(REG_LEVEL)) reg_rdata_o = AW'(trace_level);
    if (reg_addr_i >= RAW'(REG_TRACE)) reg_rdata_o = reg_addr_i[0] ? trace_dst : trace_src;
  end
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_i,
  input logic          trap_in_i,
  input logic          trap_req_o,
  input logic          trap_out_o,
  input logic          cnt_fire,
  input logic          cnt_armed,
  input logic          trace_push,
  input logic [LW-1:0] trace_level
);
  assert_ext_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in_i |=> trap_req_o);

  assert_out_implies_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_out_o |-> trap_req_o);

  assert_fire_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fire |=> trap_out_o);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_out_o |=> !trap_out_o);

  assert_disarm_after_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fire |=> !cnt_armed);

  assert_push_needs_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trace_push |-> exec_i);

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(trace_level));

  assert_level_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trace_level <= LW'(DEPTH));

  assert_level_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_push && trace_level < LW'(DEPTH)) |=> trace_level == $past(trace_level) + LW'(1));
endmodule

bind pc_watch pcw_checker #(.DEPTH(DEPTH), .LW(LVW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exec_i      (exec_i),
  .trap_in_i   (trap_in_i),
  .trap_req_o  (trap_req_o),
  .trap_out_o  (trap_out_o),
  .cnt_fire    (cnt_fire),
  .cnt_armed   (cnt_armed),
  .trace_push  (trace_push),
  .trace_level (trace_level)
);

// File: tb/pc_watch_tb.sv
module pc_watch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc_i = '0;
  logic        exec_i = 1'b0, cache_i = 1'b0, trap_in_i = 1'b0, reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        trap_req_o, trap_out_o;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pc_watch u_dut (.*);

  // Behavioural reference state
  logic [15:0] m_bp [4];
  logic [3:0]  m_en;
  logic        m_mode, m_armed, m_fire, m_ext, m_prevv;
  logic [15:0] m_cnt, m_prev;
  logic [15:0] q_src [$];
  logic [15:0] q_dst [$];

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic hit, ev;
    if (!rst_n) begin
      foreach (m_bp[i]) m_bp[i] = '0;
      m_en = '0; m_mode = 0; m_armed = 0; m_fire = 0; m_ext = 0;
      m_prevv = 0; m_cnt = '0; m_prev = '0;
      q_src.delete(); q_dst.delete();
      return;
    end
    hit = 0;
    for (int i = 0; i < 4; i++) if (exec_i && m_en[i] && m_bp[i] == pc_i) hit = 1;
    ev = m_mode ? (exec_i && cache_i) : hit;
    m_fire = 0;
    if (reg_we_i && reg_addr_i == 9) begin
      m_cnt = reg_wdata_i; m_armed = (reg_wdata_i != 0);
    end else if (m_armed && ev) begin
      if (m_cnt == 1) begin m_fire = 1; m_armed = 0; end
      m_cnt = m_cnt - 1;
    end
    m_ext = trap_in_i;
    if (exec_i) begin
      if (m_prevv && pc_i != 16'(m_prev + 16'd1)) begin
        q_src.push_back(m_prev); q_dst.push_back(pc_i);
        if (q_src.size() > 4) begin void'(q_src.pop_front()); void'(q_dst.pop_front()); end
      end
      m_prev = pc_i; m_prevv = 1;
    end
    if (reg_we_i && reg_addr_i < 4) m_bp[reg_addr_i] = reg_wdata_i;
    if (reg_we_i && reg_addr_i == 8) begin m_en = reg_wdata_i[3:0]; m_mode = reg_wdata_i[4]; end
  endtask

  function automatic logic [15:0] exp_read(int a);
    int k;
    if (a < 4) return m_bp[a];
    if (a == 8) return {11'd0, m_mode, m_en};
    if (a == 9) return m_cnt;
    if (a == 10) return 16'(q_src.size());
    if (a >= 16) begin
      k = (a - 16) / 2;
      if (k < q_src.size()) return (a % 2) ? q_dst[k] : q_src[k];
    end
    return '0;
  endfunction

  // One clock: model follows the edge, outputs compared away from it
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R3 R4 R6 trap_req_o", {15'd0, trap_req_o}, {15'd0, m_fire | m_ext});
    chk("R3 R6 trap_out_o", {15'd0, trap_out_o}, {15'd0, m_fire});
  endtask

  task automatic rd(int a, string tag);
    reg_addr_i = 5'(a);
    #1;
    chk(tag, reg_rdata_o, exp_read(a));
  endtask

  task automatic wr(int a, logic [15:0] d);
    reg_we_i = 1; reg_addr_i = 5'(a); reg_wdata_i = d;
    tick();
    reg_we_i = 0;
  endtask

  task automatic run(logic [15:0] pc, logic cache);
    exec_i = 1; pc_i = pc; cache_i = cache;
    tick();
    exec_i = 0; cache_i = 0;
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 32; a++) rd(a, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state, R9 unmapped holes, R8 empty trace
    rd(8, "R1 ctrl"); rd(9, "R1 count"); rd(10, "R1 level");
    sweep("R1 R8 R9 reset sweep");

    // R2/R3: two comparators enabled, break-count preset 2
    wr(0, 16'h0040); wr(1, 16'h0050); wr(2, 16'h0100); wr(3, 16'h0200);
    wr(8, 16'h0003); wr(9, 16'd2);
    rd(8, "R9 ctrl readback");
    for (int p = 16'h3E; p <= 16'h42; p++) run(16'(p), 0);
    rd(9, "R3 count after one hit");
    run(16'h0100, 0);
    rd(9, "R2 disabled comparator ignored");
    run(16'h0050, 0);                       // second hit fires
    rd(9, "R5 count zero after trap");
    run(16'h0040, 0); run(16'h0050, 0);
    rd(9, "R5 no retrigger without rearm");

    // R6 external trap
    trap_in_i = 1; tick(); trap_in_i = 0; tick();

    // R5 write wins over same-cycle hit, then preset 0 disarms
    reg_we_i = 1; reg_addr_i = 9; reg_wdata_i = 16'd1; exec_i = 1; pc_i = 16'h0040;
    tick(); reg_we_i = 0; exec_i = 0;
    rd(9, "R5 write precedence");
    run(16'h0041, 0); run(16'h0050, 0);
    wr(9, 16'd0); run(16'h0040, 0);
    rd(9, "R5 preset zero disarms");

    // R4 cache mode
    wr(8, 16'h0013); wr(9, 16'd3);
    run(16'h0040, 0);                        // hit ignored in cache mode
    cache_i = 1; tick(); cache_i = 0;        // cache without exec ignored
    rd(9, "R4 hit and bare cache ignored");
    run(16'h0300, 1); run(16'h0301, 1); run(16'h0302, 1); run(16'h0303, 1);
    rd(9, "R4 cache count");

    // R7 wrap is sequential; R8 saturation and ordering
    run(16'hFFFE, 0); run(16'hFFFF, 0); run(16'h0000, 0);
    tick(); tick();
    run(16'h0001, 0);
    sweep("R7 wrap and idle gaps");
    for (int j = 0; j < 7; j++) run(16'(16'h1000 + 16'h0111 * j), 0);
    sweep("R8 circular oldest first");

    // Mixed stimulus with continuous comparison
    lfsr = 16'hACE1;
    wr(8, 16'h000F); wr(9, 16'd3);
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      exec_i = lfsr[0];
      cache_i = lfsr[1];
      trap_in_i = (lfsr[6:2] == 0);
      pc_i = lfsr[3] ? 16'(m_prev + 16'd1) : {12'h000, lfsr[7:4]} << 4;
      if (n % 37 == 0) begin
        reg_we_i = 1; reg_addr_i = (n % 74 == 0) ? 5'd8 : 5'd9;
        reg_wdata_i = (n % 74 == 0) ? {11'd0, lfsr[8], 4'hF} : 16'd2;
      end
      tick();
      reg_we_i = 0;
      rd(int'(lfsr[12:8]), "R2 R3 R4 R7 R8 mixed readback");
    end
    exec_i = 0; cache_i = 0; trap_in_i = 0;
    tick();
    sweep("R8 R9 final sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule